// File: doc/BRIEF.md
# Protected-Control Watchdog Timer

This block is a watchdog for an embedded CPU. A counter advances on every machine-cycle tick from the moment power-on reset is released and never stops. When the counter reaches its last value it wraps to zero. If the reset-enable bit is set at that moment, the block drives a fixed-length reset pulse to the CPU and sets a status flag that records the watchdog as the cause. Software keeps the system alive by restarting the counter before it wraps.

The enable bit and the restart bit sit behind a timed-access lock. Software writes two key bytes in order to an access register. It must then make the protected write to the control register within a short window of machine cycles. A control write that arrives without a fresh unlock leaves both protected bits as they were. The enable bit models a nonvolatile setting: only power-on reset clears it. The watchdog pulse and the external system reset leave it alone. The status flag is not protected. Software clears it by writing 0.

The register bus has two addresses. Address 0 is the access (key) register and reads as zero. Address 1 is the control register: bit 0 is reset-enable, bit 1 is restart and bit 2 is watchdog-reset status. All other bits read as zero.

Top module: `wdt_guard`

## Requirements
- R1: The counter runs from power-on release whether the enable bit is 0 or 1. A reset pulse therefore appears on the tick that completes TIMEOUT ticks counted from power-on, even when the enable bit was set part way through that interval.
- R2: When enable is 1 and a tick completes the interval, `wd_rst_o` is high from the next clock for exactly RST_CLKS clocks, and the counter restarts from zero.
- R3: When enable is 0, completing an interval produces no pulse and leaves the status flag at 0. The counter still wraps to zero.
- R4: A protected write with bit 1 = 1 sets the counter to zero. A full TIMEOUT ticks then pass before the next timeout. Bit 1 reads back as 0 from the second clock after the write onward.
- R5: A control write made without a valid unlock changes neither the enable bit nor the counter.
- R6: The unlock is valid only after a write of 0xAA and then a write of 0x55 to address 0. Any other value written to address 0 returns the sequence to its start. A write of 0xAA always counts as a new first step, even in the middle of a sequence or after an unlock.
- R7: After the 0x55 write, a protected write is accepted while fewer than WINDOW ticks have occurred. The unlock lapses on the WINDOW-th tick.
- R8: The first control write after an unlock uses it up. A second control write needs a new unlock.
- R9: Bit 2 (status) is set by a watchdog pulse. Writing 0 to bit 2 clears it, with or without an unlock. Writing 1 to bit 2 has no effect. Power-on reset clears it.
- R10: The enable bit keeps its value through a watchdog pulse and through `sys_rst_n`. Only `por_n` clears it.
- R11: While `sys_rst_n` is low or `wd_rst_o` is high, bus writes are ignored and any pending unlock is discarded. The counter is not affected.
- R12: Address 1 reads {5'b0, status, restart, enable}. After power-on, address 1 reads 0 and `wd_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_n | input | 1 | Synchronous active-low system reset from outside the block |
| tick | input | 1 | One-clock pulse per machine cycle |
| addr | input | AW | Register address (0 = key, 1 = control) |
| wdata | input | DW | Write data |
| we | input | 1 | Write strobe |
| rdata | output | DW | Read data for `addr` |
| wd_rst_o | output | 1 | Watchdog reset pulse to the CPU |

## Verification
The unlock window is swept across every tick offset from zero to two ticks past its end. Each offset uses a write that would flip the enable bit, so acceptance and lapse each show up in the read-back. Timeouts are checked at the exact tick number, one tick early and on time. The runs start from power-on, from a restart in the middle of an interval, and from a rejected restart. An off-by-one in the counter, or a restart that is wrongly honoured or wrongly refused, moves the pulse to a different tick. Broken key sequences, repeated 0xAA writes, a reused unlock and writes during a reset each try to clear the enable bit. Each one then reads the bit back, which separates a lock that is enforced from one that is leaky.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    // Register addresses on the bus
    localparam int KEY_ADDR  = 0;
    localparam int CTRL_ADDR = 1;

    // Control register bit positions
    localparam int EN_BIT = 0;
    localparam int RS_BIT = 1;
    localparam int ST_BIT = 2;

    // Timed-access key bytes
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_guard_pkg::*;
#(
    parameter int DW     = 8,
    parameter int WINDOW = 4
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr,
    input  logic          key_we,
    input  logic [DW-1:0] key_data,
    input  logic          tick,
    input  logic          consume,
    output logic          open_o
);

    localparam int WCW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [WCW-1:0] WLAST = WCW'(WINDOW - 1);

    typedef struct packed {
        key_state_e     st;
        logic [WCW-1:0] wcnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (clr) begin
            seq_d.st   = KEY_IDLE;
            seq_d.wcnt = '0;
        end else if (key_we) begin
            // Every write to the key register restarts or advances the sequence
            if (key_data == DW'(KEY_FIRST)) begin
                seq_d.st = KEY_HALF;
            end else if (seq_q.st == KEY_HALF && key_data == DW'(KEY_SECOND)) begin
                seq_d.st = KEY_OPEN;
            end else begin
                seq_d.st = KEY_IDLE;
            end
            seq_d.wcnt = '0;
        end else if (consume) begin
            seq_d.st   = KEY_IDLE;
            seq_d.wcnt = '0;
        end else if (seq_q.st == KEY_OPEN && tick) begin
            if (seq_q.wcnt == WLAST) begin
                seq_d.st   = KEY_IDLE;
                seq_d.wcnt = '0;
            end else begin
                seq_d.wcnt = seq_q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q <= '{st: KEY_IDLE, wcnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign open_o = (seq_q.st == KEY_OPEN);

endmodule

// File: rtl/wdt_cycle_cnt.sv
module wdt_cycle_cnt #(
    parameter int TIMEOUT = 122880
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic restart_req,
    output logic restart_pend_o,
    output logic expire_o
);

    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] CLAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.pend = restart_req;
        if (cnt_q.pend) begin
            cnt_d.cnt = '0;
        end else if (tick) begin
            if (cnt_q.cnt == CLAST) begin
                cnt_d.cnt = '0;
            end else begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '{cnt: '0, pend: 1'b0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign restart_pend_o = cnt_q.pend;
    assign expire_o       = tick && !cnt_q.pend && (cnt_q.cnt == CLAST);

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int RST_CLKS = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic fire,
    output logic rst_o
);

    localparam int RCW = $clog2(RST_CLKS + 1);
    localparam logic [RCW-1:0] RFULL = RCW'(RST_CLKS);

    typedef struct packed {
        logic [RCW-1:0] left;
    } pls_t;

    pls_t pls_d, pls_q;

    always_comb begin
        pls_d = pls_q;
        if (fire) begin
            pls_d.left = RFULL;
        end else if (pls_q.left != '0) begin
            pls_d.left = pls_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pls_q <= '{left: '0};
        end else begin
            pls_q <= pls_d;
        end
    end

    assign rst_o = (pls_q.left != '0);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int AW       = 2,
    parameter int DW       = 8,
    parameter int TIMEOUT  = 122880,
    parameter int WINDOW   = 4,
    parameter int RST_CLKS = 4
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          tick,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output logic          wd_rst_o
);

    localparam logic [AW-1:0] A_KEY  = AW'(KEY_ADDR);
    localparam logic [AW-1:0] A_CTRL = AW'(CTRL_ADDR);

    typedef struct packed {
        logic en;
        logic stat;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic clr;
    logic wr_key, wr_ctl, prot_wr;
    logic key_open;
    logic restart_req, restart_pend;
    logic expire, fire;
    logic en_w, stat_w;

    // Writes are dropped while the CPU is held in reset
    assign clr     = !sys_rst_n || wd_rst_o;
    assign wr_key  = we && !clr && (addr == A_KEY);
    assign wr_ctl  = we && !clr && (addr == A_CTRL);
    assign prot_wr = wr_ctl && key_open;

    assign restart_req = prot_wr && wdata[RS_BIT];
    assign fire        = expire && ctrl_q.en;

    wdt_key_seq #(
        .DW     (DW),
        .WINDOW (WINDOW)
    ) u_key (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (clr),
        .key_we   (wr_key),
        .key_data (wdata),
        .tick     (tick),
        .consume  (wr_ctl),
        .open_o   (key_open)
    );

    wdt_cycle_cnt #(
        .TIMEOUT (TIMEOUT)
    ) u_cnt (
        .clk            (clk),
        .por_n          (por_n),
        .tick           (tick),
        .restart_req    (restart_req),
        .restart_pend_o (restart_pend),
        .expire_o       (expire)
    );

    wdt_rst_pulse #(
        .RST_CLKS (RST_CLKS)
    ) u_pls (
        .clk   (clk),
        .por_n (por_n),
        .fire  (fire),
        .rst_o (wd_rst_o)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (prot_wr) begin
            ctrl_d.en = wdata[EN_BIT];
        end
        if (fire) begin
            ctrl_d.stat = 1'b1;
        end else if (wr_ctl && !wdata[ST_BIT]) begin
            ctrl_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl_q <= '{en: 1'b0, stat: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[EN_BIT] = ctrl_q.en;
            rdata[RS_BIT] = restart_pend;
            rdata[ST_BIT] = ctrl_q.stat;
        end
    end

    assign en_w   = ctrl_q.en;
    assign stat_w = ctrl_q.stat;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter int RST_CLKS = 4
) (
    input logic clk,
    input logic por_n,
    input logic expire,
    input logic en,
    input logic stat,
    input logic wd_rst_o,
    input logic restart_pend,
    input logic restart_req,
    input logic key_open,
    input logic wr_ctl
);

    localparam int HW = $clog2(RST_CLKS + 2);

    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_q <= '0;
        end else if (wd_rst_o) begin
            hi_q <= hi_q + 1'b1;
        end else begin
            hi_q <= '0;
        end
    end

    assert_pulse_after_expire_R2: assert property (@(posedge clk) disable iff (!por_n)
        (expire && en) |=> wd_rst_o);

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!por_n)
        wd_rst_o |-> (hi_q < HW'(RST_CLKS)));

    assert_no_pulse_disabled_R3: assert property (@(posedge clk) disable iff (!por_n)
        (expire && !en && !wd_rst_o) |=> !wd_rst_o);

    assert_restart_selfclear_R4: assert property (@(posedge clk) disable iff (!por_n)
        (restart_pend && !restart_req) |=> !restart_pend);

    assert_locked_enable_R5: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_ctl && key_open) |=> $stable(en));

    assert_status_on_pulse_R9: assert property (@(posedge clk) disable iff (!por_n)
        (expire && en) |=> stat);

endmodule

bind wdt_guard wdt_guard_chk #(.RST_CLKS(RST_CLKS)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .expire       (expire),
    .en           (en_w),
    .stat         (stat_w),
    .wd_rst_o     (wd_rst_o),
    .restart_pend (restart_pend),
    .restart_req  (restart_req),
    .key_open     (key_open),
    .wr_ctl       (wr_ctl)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;

    localparam int AW  = 2;
    localparam int DW  = 8;
    localparam int TO  = 20;
    localparam int WIN = 4;
    localparam int RC  = 3;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          sys_rst_n = 1'b1;
    logic          tick = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          we = 1'b0;
    logic [DW-1:0] rdata;
    logic          wd_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wdt_guard #(
        .AW(AW), .DW(DW), .TIMEOUT(TO), .WINDOW(WIN), .RST_CLKS(RC)
    ) u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
        .addr(addr), .wdata(wdata), .we(we), .rdata(rdata), .wd_rst_o(wd_rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); wdata = DW'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_ctrl(output int v);
        addr = AW'(1);
        #1;
        v = int'(rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic unlock();
        wr(0, 8'hAA);
        wr(0, 8'h55);
    endtask

    task automatic prot(input int d);
        unlock();
        wr(1, d);
    endtask

    task automatic wait_low();
        while (wd_rst_o) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        int hi;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd_ctrl(v); chk("R12 ctrl after por", v, 0);
        chk("R12 pulse after por", int'(wd_rst_o), 0);
        addr = AW'(0); #1; chk("R12 key reads zero", int'(rdata), 0);

        // R7 window sweep, enable flips only if accepted
        for (int k = 0; k <= WIN + 1; k++) begin
            unlock();
            ticks(k);
            wr(1, 8'h01);
            rd_ctrl(v); chk($sformatf("R7 window offset %0d", k), v & 1, (k < WIN) ? 1 : 0);
            if ((v & 1) == 1) prot(8'h00);
        end

        // R3 disabled timeouts: pass more than one interval
        ticks(2 * TO);
        rd_ctrl(v); chk("R3 no status when disabled", v, 0);
        chk("R3 no pulse when disabled", int'(wd_rst_o), 0);

        // R1 counting from power-on, enable set mid-interval
        do_por();
        ticks(5);
        prot(8'h01);
        rd_ctrl(v); chk("R1 enable accepted", v, 1);
        ticks(TO - 6);
        chk("R1 no pulse one tick early", int'(wd_rst_o), 0);
        ticks(1);
        chk("R1 pulse at interval end", int'(wd_rst_o), 1);
        hi = 0;
        while (wd_rst_o) begin hi++; @(negedge clk); end
        chk("R2 pulse width", hi, RC);
        rd_ctrl(v); chk("R9 R10 status set enable kept", v, 5);

        // R9 status semantics and R5 ordinary write
        wr(1, 8'h01); rd_ctrl(v); chk("R9 status cleared by 0", v, 1);
        wr(1, 8'h04); rd_ctrl(v); chk("R9 writing 1 no effect", v, 1);
        wr(1, 8'h00); rd_ctrl(v); chk("R5 enable locked", v, 1);

        // R4 restart mid interval
        ticks(10);
        prot(8'h03);
        @(negedge clk);
        rd_ctrl(v); chk("R4 restart self clears", v, 1);
        ticks(TO - 1);
        chk("R4 no pulse before full interval", int'(wd_rst_o), 0);
        ticks(1);
        chk("R4 pulse after full interval", int'(wd_rst_o), 1);
        wait_low();

        // R5 restart ignored without unlock, R11 write during pulse
        ticks(10);
        wr(1, 8'h03);
        ticks(TO - 11);
        chk("R5 no pulse early", int'(wd_rst_o), 0);
        ticks(1);
        chk("R5 unprotected restart ignored", int'(wd_rst_o), 1);
        wr(1, 8'h01);
        wait_low();
        rd_ctrl(v); chk("R11 write during pulse ignored", v, 5);
        wr(1, 8'h01);

        // R7 restart accepted inside window
        unlock(); ticks(3); wr(1, 8'h03);
        ticks(TO - 1);
        chk("R7 restart in window no pulse", int'(wd_rst_o), 0);
        ticks(1);
        chk("R7 restart in window pulse", int'(wd_rst_o), 1);
        wait_low();
        wr(1, 8'h01);

        // R7 lapse rejects restart and enable clear
        unlock(); ticks(WIN); wr(1, 8'h02);
        rd_ctrl(v); chk("R7 lapsed write enable", v, 1);
        ticks(TO - WIN - 1);
        chk("R7 lapsed no early pulse", int'(wd_rst_o), 0);
        ticks(1);
        chk("R7 lapsed restart ignored", int'(wd_rst_o), 1);
        wait_low();
        wr(1, 8'h01);

        // R8 unlock used up
        unlock(); wr(1, 8'h01); wr(1, 8'h00);
        rd_ctrl(v); chk("R8 second write rejected", v, 1);

        // R6 sequence rules
        wr(0, 8'hAA); wr(0, 8'h12); wr(0, 8'h55); wr(1, 8'h00);
        rd_ctrl(v); chk("R6 broken sequence", v, 1);
        wr(0, 8'hAA); wr(0, 8'hAA); wr(0, 8'h55); wr(1, 8'h00);
        rd_ctrl(v); chk("R6 repeated first key", v, 0);
        unlock(); wr(0, 8'h55); wr(1, 8'h01);
        rd_ctrl(v); chk("R6 key write after unlock", v, 0);
        prot(8'h01);
        rd_ctrl(v); chk("R6 plain unlock", v, 1);

        // R10 R11 system reset
        unlock();
        @(negedge clk); sys_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        sys_rst_n = 1'b1;
        wr(1, 8'h00);
        rd_ctrl(v); chk("R11 unlock dropped by sys reset", v, 1);
        ticks(TO - 1);
        chk("R11 counter unaffected no pulse", int'(wd_rst_o), 0);
        ticks(1);
        chk("R11 counter unaffected pulse", int'(wd_rst_o), 1);
        wait_low();
        rd_ctrl(v); chk("R10 enable survives pulse", v, 5);

        // R10 R9 power-on clears
        do_por();
        rd_ctrl(v); chk("R10 R9 por clears", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule